// File: doc/BRIEF.md
# Serial Master Receiver

This block is a receive-only synchronous serial master. It drives a serial clock at half the system clock rate and shifts in one data bit on each rising edge of that clock, most significant bit first. A small register-style host port holds a control register, a status register and a receive-data register.

Software sets the power and receive enables. It then starts a transfer with a dummy read of the receive-data register. Every completed word raises a one-cycle interrupt and lands in the receive-data register. A continue bit in the control register is sampled when a word completes. When it is set, the next word follows with no gap. When it is clear, the serial clock parks high and the busy flag drops.

An overrun flag records that a word completed while the previous word was still unread. The new word replaces the old one. Software clears the flag by writing 0 to it.

Top module: `ser_rx_master`

## Requirements
- R1: After reset, sclk_o is 1, rx_done_irq is 0, the status register reads 0 and the control register reads 0.
- R2: A read (reg_rd) of address 2 while control bits 0 (power) and 1 (receive) are both 1 and status bit 0 (busy) is 0 sets busy from the next cycle. With either enable at 0, the read leaves busy at 0 and sclk_o at 1.
- R3: While busy, sclk_o inverts on every system clock. When not busy, sclk_o holds 1.
- R4: Each word is WORD_W (8) bits, sampled from sdi_i at the rising edges of sclk_o, MSB first, and readable at address 2 once the word completes.
- R5: rx_done_irq is high for exactly one cycle per word. In a single transfer it is first seen 2*WORD_W+1 cycles after the starting read's clock edge.
- R6: If control bit 2 (continue) is 1 when a word completes, busy stays 1 and the next word follows. The interrupts are then 2*WORD_W cycles apart.
- R7: If the continue bit is 0 when a word completes, busy is 0 in the interrupt cycle and sclk_o stays 1 with no further interrupt.
- R8: When a word completes while the previous word has not been read at address 2, status bit 1 (overrun) becomes 1 and the new word replaces the old one.
- R9: A write to address 1 with data bit 1 at 0 clears overrun. A write with bit 1 at 1 leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register address: 0 control, 1 status, 2 receive data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of address 2 can start reception) |
| reg_wdata | input | WORD_W | Write data |
| reg_rdata | output | WORD_W | Read data for reg_addr, combinational |
| sclk_o | output | 1 | Serial clock, idles high |
| sdi_i | input | 1 | Serial data input |
| rx_done_irq | output | 1 | One-cycle word-complete interrupt |

## Verification
The assertions assume the host changes the power and receive enables only while busy reads 0. They also assume that a clearing write to the status register and a word completion do not arrive in the same cycle. Under these assumptions the overrun flag's stickiness and the busy and clock relations hold. The stimulus clears enables only after a word has ended. It writes the status register only while idle. The serial data model changes its bit on the rising edge of sclk_o, after the design has sampled it, so the sampled value is always well defined.

// File: rtl/ser_rx_master.sv
`timescale 1ns/1ps
module ser_rx_master #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              sclk_o,
  input  logic              sdi_i,
  output logic              rx_done_irq
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_RX   = 2'd2;

  logic [2:0]        ctrl_q;
  logic              busy_q, sclk_q, ovr_q, unread_q, irq_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] sh_q, rx_q;

  wire rx_rd  = reg_rd && (reg_addr == A_RX);
  wire start  = rx_rd && ctrl_q[0] && ctrl_q[1] && !busy_q;
  wire rise   = busy_q && !sclk_q;
  wire last   = rise && (cnt_q == CNT_W'(WORD_W-1));
  wire [WORD_W-1:0] next_sh = {sh_q[WORD_W-2:0], sdi_i};
  wire unused_wdata = ^reg_wdata[WORD_W-1:3];

  assign sclk_o      = sclk_q;
  assign rx_done_irq = irq_q;

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = WORD_W'(ctrl_q);
      A_STAT:  reg_rdata = WORD_W'({ovr_q, busy_q});
      A_RX:    reg_rdata = rx_q;
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      busy_q   <= 1'b0;
      sclk_q   <= 1'b1;
      ovr_q    <= 1'b0;
      unread_q <= 1'b0;
      irq_q    <= 1'b0;
      cnt_q    <= '0;
      sh_q     <= '0;
      rx_q     <= '0;
    end else begin
      irq_q <= last;
      if (reg_wr && reg_addr == A_CTRL) ctrl_q <= reg_wdata[2:0];
      if (start) begin
        busy_q <= 1'b1;
        sclk_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        sclk_q <= ~sclk_q;
        if (rise) begin
          sh_q  <= next_sh;
          cnt_q <= cnt_q + 1'b1;
        end
        if (last) begin
          rx_q   <= next_sh;
          cnt_q  <= '0;
          busy_q <= ctrl_q[2];
        end
      end
      if (last) unread_q <= 1'b1;
      else if (rx_rd) unread_q <= 1'b0;
      if (last && unread_q && !rx_rd) ovr_q <= 1'b1;
      else if (reg_wr && reg_addr == A_STAT && !reg_wdata[1]) ovr_q <= 1'b0;
    end
  end

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_RX && ctrl_q[0] && ctrl_q[1] && !busy_q) |=> busy_q);
  p_idle_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> sclk_o);
  p_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> (sclk_o != $past(sclk_o)));
  p_done_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done_irq |-> sclk_o);
  p_irq_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done_irq |=> !rx_done_irq);
  p_cont_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done_irq |-> (busy_q == $past(ctrl_q[2])));
  p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !(reg_wr && reg_addr == A_STAT && !reg_wdata[1])) |=> ovr_q);
endmodule

// File: tb/ser_rx_master_bench.sv
`timescale 1ns/1ps
module ser_rx_master_bench;
  localparam int W = 8;
  localparam int NV = 6;
  localparam logic [W-1:0] VEC [NV] = '{8'hA5, 8'h00, 8'hFF, 8'h81, 8'h3C, 8'h7E};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic sclk, sdi, irq;
  logic [W-1:0] words [8];
  int bidx = 0;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  assign sdi = words[(bidx / W) % 8][W-1-(bidx % W)];
  always @(posedge sclk) bidx <= bidx + 1;

  ser_rx_master #(.WORD_W(W)) u_ser_rx_master (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sclk_o(sclk), .sdi_i(sdi), .rx_done_irq(irq));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic peek(input logic [1:0] a, output int v);
    reg_addr = a;
    #1;
    v = int'(reg_rdata);
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_rx();
    reg_addr = 2'd2; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    do begin
      @(negedge clk);
      reg_rd = 1'b0;
      reg_wr = 1'b0;
      n++;
    end while (!irq && n < 200);
    if (!irq) begin
      errors++;
      $display("FAIL R5: no interrupt within 200 cycles");
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int v, n;
    for (int i = 0; i < 8; i++) words[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 sclk", int'(sclk), 1);
    chk("R1 irq", int'(irq), 0);
    peek(2'd1, v); chk("R1 status", v, 0);
    peek(2'd0, v); chk("R1 control", v, 0);

    // R2: start ignored without both enables
    wr(2'd0, 8'h01);
    rd_rx();
    repeat (3) @(negedge clk);
    peek(2'd1, v); chk("R2 no start busy", v & 1, 0);
    chk("R2 no start sclk", int'(sclk), 1);
    chk("R2 no start irq", int'(irq), 0);

    // Vector table: single transfers (R2 R4 R5 R7)
    wr(2'd0, 8'h03);
    for (int i = 0; i < NV; i++) begin
      words[0] = VEC[i];
      bidx = 0;
      reg_addr = 2'd2; reg_rd = 1'b1;
      wait_irq(n);
      chk("R5 latency", n, 2*W+1);
      peek(2'd2, v); chk("R4 data", v, int'(VEC[i]));
      peek(2'd1, v); chk("R7 busy off", v, 0);
      chk("R3 idle high", int'(sclk), 1);
      @(negedge clk);
      chk("R5 one cycle", int'(irq), 0);
    end

    // R6 continuous, then R7 stop mid-run
    words[0] = 8'h11; words[1] = 8'h22; words[2] = 8'h33;
    bidx = 0;
    wr(2'd0, 8'h07);
    reg_addr = 2'd2; reg_rd = 1'b1;
    wait_irq(n);
    chk("R6 first latency", n, 2*W+1);
    peek(2'd2, v); chk("R6 word0", v, 8'h11);
    peek(2'd1, v); chk("R6 busy kept", v & 1, 1);
    reg_addr = 2'd2; reg_rd = 1'b1;
    wait_irq(n);
    chk("R6 interval", n, 2*W);
    peek(2'd2, v); chk("R6 word1", v, 8'h22);
    rd_rx();
    wr(2'd0, 8'h03);
    wait_irq(n);
    chk("R7 interval", n, 2*W-2);
    peek(2'd2, v); chk("R7 word2", v, 8'h33);
    peek(2'd1, v); chk("R7 stopped no overrun", v, 0);
    v = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (irq || !sclk) v++;
    end
    chk("R7 quiet after stop", v, 0);

    // R8 overrun, R9 clear
    words[0] = 8'h5A; words[1] = 8'hC3;
    bidx = 0;
    wr(2'd0, 8'h07);
    reg_addr = 2'd2; reg_rd = 1'b1;
    wait_irq(n);
    peek(2'd1, v); chk("R8 no overrun yet", v, 1);
    wr(2'd0, 8'h03);
    wait_irq(n);
    chk("R8 interval", n, 2*W-1);
    peek(2'd1, v); chk("R8 overrun set", v, 2);
    peek(2'd2, v); chk("R8 new word kept", v, 8'hC3);
    @(negedge clk);
    wr(2'd1, 8'h02);
    peek(2'd1, v); chk("R9 write one keeps", v, 2);
    wr(2'd1, 8'h00);
    peek(2'd1, v); chk("R9 write zero clears", v, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule